// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block sits beside one processor and decides which of 256 interrupt vectors that processor should take next. Incoming deliveries set a bit in a 256-bit pending set. A parallel 256-bit level map remembers whether each accepted vector came in level-triggered. A third 256-bit set tracks the vectors the processor has taken but not yet retired. The priority class of a vector is its upper four bits. The block raises its request line only when the best pending class beats both the best in-service class and a software-set threshold.

The processor answers the request line with an acknowledge pulse. One cycle later it gets the vector. If nothing qualified, it gets a programmable fallback vector. An end-of-service write retires the highest in-service vector. If that vector was level-triggered, the block emits a one-cycle notify pulse carrying the vector, so that the interrupt sources can re-arm. A bypass delivery drives the processor directly through a one-entry holding slot and never touches the three sets. Deliveries of system event kinds are passed straight out as a pulse with their kind code. A small register port exposes the threshold, the fallback vector with its master enable, and a sticky error byte.

Top module: `irq_prio_core`

## Requirements
- R1: A delivery with kind 0 (fixed) or 1 (lowest priority), bypass low, vector 16 or above, and the enable bit set makes that vector pending. The level map bit for the vector becomes `dlv_level` (1 = level, 0 = edge).
- R2: `intr` is high when three conditions hold: a vector is pending, the upper four bits of the highest pending vector exceed those of the highest in-service vector (taken as 0 when none is in service), and they exceed bits [7:4] of the threshold register (address 0, bits [7:0], reset 0).
- R3: An `ack` while a pending vector qualifies clears that vector's pending bit and sets its in-service bit. On the next cycle `ack_valid` pulses with `ack_vector` set to that vector.
- R4: An `ack` while nothing qualifies and no bypass vector is held returns the fallback vector (address 1, bits [7:0], reset 0xFF) one cycle later and changes no set.
- R5: An `eoi_wr` clears the highest in-service bit. If that vector's level map bit is 1, `eoi_bcast` pulses on the next cycle with `eoi_vector` equal to it.
- R6: Retiring an edge-triggered vector, or an `eoi_wr` with nothing in service, produces no `eoi_bcast`.
- R7: While the enable bit (address 1, bit 8, reset 0) is clear, fixed and lowest-priority deliveries are ignored.
- R8: A fixed or lowest-priority delivery with a vector below 16 never becomes pending and sets bit 6 (value 0x40) of the error register (address 2). Any write to address 2 clears that register, but a same-cycle error wins over the clear.
- R9: An accepted delivery with `dlv_bypass` high raises `intr` without touching the three sets. The next `ack` returns the held vector ahead of any pending one.
- R10: `deassert_valid` clears the pending bit of `deassert_vector` only when that vector's level map bit is 1 and it is not in service.
- R11: A delivery of kind 2, 4, 5, 6 or 7 pulses `sys_evt_valid` one cycle later with `sys_evt_kind` equal to the kind, and does not make anything pending. Kind 3 has no effect.
- R12: An `ack` and an `eoi_wr` in the same cycle both take effect: the retire acts on the old in-service set, and the acknowledge acts on the old pending set.
- R13: After reset `intr`, `ack_valid`, `eoi_bcast` and `sys_evt_valid` are low and all three sets are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dlv_valid | input | 1 | Delivery strobe |
| dlv_vector | input | 8 | Delivered vector |
| dlv_mode | input | 3 | Delivery kind |
| dlv_level | input | 1 | 1 = level-triggered, 0 = edge |
| dlv_bypass | input | 1 | Deliver straight to the processor |
| deassert_valid | input | 1 | Level source went inactive |
| deassert_vector | input | 8 | Vector whose source went inactive |
| ack | input | 1 | Processor acknowledge pulse |
| eoi_wr | input | 1 | End-of-service write |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| intr | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | Acknowledged vector is valid |
| ack_vector | output | 8 | Acknowledged or fallback vector |
| eoi_bcast | output | 1 | Level vector retired, notify sources |
| eoi_vector | output | 8 | Vector carried by the notify pulse |
| sys_evt_valid | output | 1 | System event delivery seen |
| sys_evt_kind | output | 3 | Kind code of the system event |
| reg_rdata | output | 32 | Read data for `reg_addr` |

## Verification
The acknowledge and the retire of a previous vector can land in the same clock. The bench drives `ack` and `eoi_wr` together while one edge vector is in service and a higher-class level vector is pending. It then expects the edge vector gone without a notify and the pending vector acknowledged. A following retire must then produce the notify for the level vector. A delivery that coincides with an acknowledge or a deassert of the same vector is also driven. The behavioural model expects the new delivery to win, and every output is compared with that model on each clock.

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
  parameter int VW            = 8,
  parameter int ILLEGAL_LIMIT = 16,
  parameter int DW            = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dlv_valid,
  input  logic [VW-1:0] dlv_vector,
  input  logic [2:0]    dlv_mode,
  input  logic          dlv_level,
  input  logic          dlv_bypass,
  input  logic          deassert_valid,
  input  logic [VW-1:0] deassert_vector,
  input  logic          ack,
  input  logic          eoi_wr,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          intr,
  output logic          ack_valid,
  output logic [VW-1:0] ack_vector,
  output logic          eoi_bcast,
  output logic [VW-1:0] eoi_vector,
  output logic          sys_evt_valid,
  output logic [2:0]    sys_evt_kind,
  output logic [DW-1:0] reg_rdata
);
  localparam int NV   = 1 << VW;
  localparam int CW   = 4;
  localparam int ERRB = 6;

  logic [NV-1:0] irr, isr, tmr;
  logic [VW-1:0] tpr;
  logic [VW:0]   spur;
  logic [7:0]    esr;
  logic          byp_pend;
  logic [VW-1:0] byp_vec;

  function automatic logic [VW:0] top_bit(input logic [NV-1:0] v);
    logic [VW:0] r;
    r = '0;
    for (int i = 0; i < NV; i++)
      if (v[i]) r = {1'b1, VW'(i)};
    return r;
  endfunction

  logic [VW:0]   pend_top, svc_top;
  logic          pend_any, svc_any;
  logic [VW-1:0] pend_idx, svc_idx;
  logic [CW-1:0] pend_cls, svc_cls, tpr_cls;
  logic          qualify;

  assign pend_top = top_bit(irr);
  assign svc_top  = top_bit(isr);
  assign pend_any = pend_top[VW];
  assign svc_any  = svc_top[VW];
  assign pend_idx = pend_top[VW-1:0];
  assign svc_idx  = svc_top[VW-1:0];
  assign pend_cls = pend_idx[VW-1:VW-CW];
  assign svc_cls  = svc_any ? svc_idx[VW-1:VW-CW] : '0;
  assign tpr_cls  = tpr[VW-1:VW-CW];
  assign qualify  = pend_any && (pend_cls > svc_cls) && (pend_cls > tpr_cls);
  assign intr     = byp_pend || qualify;

  logic sw_en, is_norm, is_sys, illegal, accept, take_irr, take_byp, rx_err;
  assign sw_en    = spur[VW];
  assign is_norm  = (dlv_mode == 3'd0) || (dlv_mode == 3'd1);
  assign is_sys   = (dlv_mode == 3'd2) || (dlv_mode >= 3'd4);
  assign illegal  = dlv_vector < VW'(ILLEGAL_LIMIT);
  assign accept   = dlv_valid && is_norm && sw_en && !illegal;
  assign take_irr = accept && !dlv_bypass;
  assign take_byp = accept && dlv_bypass;
  assign rx_err   = dlv_valid && is_norm && illegal;

  logic ack_real, drop_ok;
  assign ack_real = ack && !byp_pend && qualify;
  assign drop_ok  = deassert_valid && tmr[deassert_vector] && !isr[deassert_vector];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
      tmr <= '0;
    end else begin
      if (ack_real) begin
        irr[pend_idx] <= 1'b0;
        isr[pend_idx] <= 1'b1;
      end
      if (eoi_wr && svc_any) isr[svc_idx] <= 1'b0;
      if (drop_ok) irr[deassert_vector] <= 1'b0;
      if (take_irr) begin
        irr[dlv_vector] <= 1'b1;
        tmr[dlv_vector] <= dlv_level;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_pend   <= 1'b0;
      byp_vec    <= '0;
      ack_valid  <= 1'b0;
      ack_vector <= '0;
    end else begin
      ack_valid <= ack;
      if (ack) begin
        if (byp_pend)     ack_vector <= byp_vec;
        else if (qualify) ack_vector <= pend_idx;
        else              ack_vector <= spur[VW-1:0];
        byp_pend <= 1'b0;
      end
      if (take_byp) begin
        byp_pend <= 1'b1;
        byp_vec  <= dlv_vector;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoi_bcast  <= 1'b0;
      eoi_vector <= '0;
    end else begin
      eoi_bcast <= eoi_wr && svc_any && tmr[svc_idx];
      if (eoi_wr && svc_any && tmr[svc_idx]) eoi_vector <= svc_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_evt_valid <= 1'b0;
      sys_evt_kind  <= '0;
    end else begin
      sys_evt_valid <= dlv_valid && is_sys;
      if (dlv_valid && is_sys) sys_evt_kind <= dlv_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr  <= '0;
      spur <= {1'b0, {VW{1'b1}}};
      esr  <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) tpr  <= reg_wdata[VW-1:0];
      if (reg_wr && reg_addr == 2'd1) spur <= reg_wdata[VW:0];
      if (rx_err)                          esr[ERRB] <= 1'b1;
      else if (reg_wr && reg_addr == 2'd2) esr <= '0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0:    reg_rdata[VW-1:0] = tpr;
      2'd1:    reg_rdata[VW:0]   = spur;
      2'd2:    reg_rdata[7:0]    = esr;
      default: reg_rdata         = '0;
    endcase
  end

  // R3
  ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ack_valid);

  // R5
  eoi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast |-> $past(eoi_wr));

  // R7
  disabled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !sw_en && !ack && !deassert_valid) |=> $stable(irr));

  // R8
  illegal_nopend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && illegal) |=> !irr[$past(dlv_vector)]);

  // R11
  sys_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_evt_valid |-> $past(dlv_valid));

  // R2
  intr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intr |-> (byp_pend || irr != '0));

endmodule

// File: tb/sim_irq_prio_core.sv
module sim_irq_prio_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dlv_valid = 0, dlv_level = 0, dlv_bypass = 0;
  logic [7:0] dlv_vector = 0;
  logic [2:0] dlv_mode = 0;
  logic deassert_valid = 0;
  logic [7:0] deassert_vector = 0;
  logic ack = 0, eoi_wr = 0, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic intr, ack_valid, eoi_bcast, sys_evt_valid;
  logic [7:0] ack_vector, eoi_vector;
  logic [2:0] sys_evt_kind;
  logic [31:0] reg_rdata;

  always #5 clk = ~clk;

  irq_prio_core u0 (
    .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_vector(dlv_vector),
    .dlv_mode(dlv_mode), .dlv_level(dlv_level), .dlv_bypass(dlv_bypass),
    .deassert_valid(deassert_valid), .deassert_vector(deassert_vector),
    .ack(ack), .eoi_wr(eoi_wr), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .intr(intr), .ack_valid(ack_valid),
    .ack_vector(ack_vector), .eoi_bcast(eoi_bcast), .eoi_vector(eoi_vector),
    .sys_evt_valid(sys_evt_valid), .sys_evt_kind(sys_evt_kind),
    .reg_rdata(reg_rdata));

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit checking = 0;
  string cur_req = "R13";

  bit m_irr[256], m_isr[256], m_tmr[256];
  int m_tpr = 0, m_spur = 'h0FF, m_esr = 0;
  bit m_bp = 0; int m_bpv = 0;
  bit m_ackv = 0; int m_ackvec = 0;
  bit m_eoib = 0; int m_eoiv = 0;
  bit m_evt = 0; int m_evtk = 0;

  function automatic int top_of(input bit a[256]);
    int r = -1;
    foreach (a[i]) if (a[i]) r = i;
    return r;
  endfunction

  function automatic bit m_qual();
    int hp = top_of(m_irr), hi = top_of(m_isr);
    int hc = (hi < 0) ? 0 : hi / 16;
    return hp >= 0 && (hp / 16) > hc && (hp / 16) > (m_tpr / 16);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      foreach (m_irr[i]) begin m_irr[i] = 0; m_isr[i] = 0; m_tmr[i] = 0; end
      m_tpr = 0; m_spur = 'h0FF; m_esr = 0; m_bp = 0; m_bpv = 0;
      m_ackv = 0; m_ackvec = 0; m_eoib = 0; m_eoiv = 0; m_evt = 0; m_evtk = 0;
    end else begin
      bit old_isr[256], old_tmr[256];
      int hp, hi;
      bit q, norm;
      old_isr = m_isr; old_tmr = m_tmr;
      hp = top_of(m_irr); hi = top_of(m_isr); q = m_qual();
      m_ackv = ack; m_eoib = 0; m_evt = 0;
      if (ack) begin
        if (m_bp) m_ackvec = m_bpv;
        else if (q) begin m_irr[hp] = 0; m_isr[hp] = 1; m_ackvec = hp; end
        else m_ackvec = m_spur % 256;
        m_bp = 0;
      end
      if (eoi_wr && hi >= 0) begin
        m_isr[hi] = 0;
        if (old_tmr[hi]) begin m_eoib = 1; m_eoiv = hi; end
      end
      if (deassert_valid && old_tmr[deassert_vector] && !old_isr[deassert_vector])
        m_irr[deassert_vector] = 0;
      norm = dlv_mode == 0 || dlv_mode == 1;
      if (dlv_valid && norm) begin
        if (dlv_vector < 16) m_esr = 'h40;
        else if (m_spur >= 256) begin
          if (dlv_bypass) begin m_bp = 1; m_bpv = dlv_vector; end
          else begin m_irr[dlv_vector] = 1; m_tmr[dlv_vector] = dlv_level; end
        end
      end
      if (dlv_valid && dlv_mode != 3 && !norm) begin m_evt = 1; m_evtk = dlv_mode; end
      if (reg_wr && reg_addr == 0) m_tpr = reg_wdata[7:0];
      if (reg_wr && reg_addr == 1) m_spur = reg_wdata[8:0];
      if (reg_wr && reg_addr == 2 && !(dlv_valid && norm && dlv_vector < 16)) m_esr = 0;
    end
  end

  task automatic chk(input string nm, input logic [31:0] a, input logic [31:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, nm, a, e);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (checking) begin
      int rd;
      rd = (reg_addr == 0) ? m_tpr : (reg_addr == 1) ? m_spur : (reg_addr == 2) ? m_esr : 0;
      chk("intr", intr, m_bp || m_qual());
      chk("ack_valid", ack_valid, m_ackv);
      chk("ack_vector", ack_vector, m_ackvec);
      chk("eoi_bcast", eoi_bcast, m_eoib);
      chk("eoi_vector", eoi_vector, m_eoiv);
      chk("sys_evt_valid", sys_evt_valid, m_evt);
      chk("sys_evt_kind", sys_evt_kind, m_evtk);
      chk("reg_rdata", reg_rdata, rd);
    end
  end

  task automatic tick();
    @(negedge clk);
    dlv_valid = 0; dlv_bypass = 0; dlv_level = 0; dlv_mode = 0;
    deassert_valid = 0; ack = 0; eoi_wr = 0; reg_wr = 0;
  endtask
  task automatic dlv(input int v, input int m, input bit lvl, input bit byp);
    dlv_valid = 1; dlv_vector = v[7:0]; dlv_mode = m[2:0]; dlv_level = lvl; dlv_bypass = byp;
  endtask
  task automatic wr(input int a, input int d);
    reg_wr = 1; reg_addr = a[1:0]; reg_wdata = d;
  endtask
  task automatic drop(input int v);
    deassert_valid = 1; deassert_vector = v[7:0];
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checking = 1;
    cur_req = "R13"; idle(2);
    rst_n = 1; idle(2);

    cur_req = "R7"; dlv('h40, 0, 0, 0); tick(); idle(2);
    reg_addr = 1; wr(1, 'h1F0); tick(); idle(1);

    cur_req = "R1"; dlv('h45, 0, 0, 0); tick(); dlv('h32, 1, 1, 0); tick(); idle(1);
    cur_req = "R3"; ack = 1; tick(); idle(1);
    cur_req = "R2"; ack = 1; tick(); idle(1);
    cur_req = "R5"; eoi_wr = 1; tick(); idle(1);
    cur_req = "R6"; eoi_wr = 1; tick(); idle(1); eoi_wr = 1; tick(); idle(1);

    cur_req = "R2"; reg_addr = 0; wr(0, 'h50); tick(); dlv('h52, 0, 0, 0); tick(); idle(2);
    cur_req = "R4"; ack = 1; tick(); idle(2);
    cur_req = "R2"; wr(0, 'h40); tick(); idle(1); ack = 1; tick(); eoi_wr = 1; tick(); idle(1);
    wr(0, 0); tick();

    cur_req = "R8"; reg_addr = 2; dlv('h05, 0, 1, 0); tick(); idle(1);
    wr(2, 0); tick(); idle(1);
    dlv('h0F, 1, 0, 0); wr(2, 0); tick(); idle(1);
    wr(2, 0); tick(); idle(1);

    cur_req = "R9"; dlv('h90, 0, 0, 0); tick(); dlv('h20, 0, 1, 1); tick(); idle(1);
    ack = 1; tick(); idle(1); ack = 1; tick(); idle(1);
    eoi_wr = 1; tick(); idle(1); eoi_wr = 1; tick(); idle(1);
    ack = 1; tick(); idle(1);

    cur_req = "R10"; dlv('h83, 0, 1, 0); tick(); idle(1); drop('h83); tick(); idle(1);
    dlv('h84, 0, 0, 0); tick(); drop('h84); tick(); idle(1); ack = 1; tick(); idle(1);
    dlv('h87, 0, 1, 0); tick(); ack = 1; tick(); drop('h87); tick(); idle(1);
    eoi_wr = 1; tick(); eoi_wr = 1; tick(); idle(1);
    dlv('h88, 0, 1, 0); drop('h88); tick(); idle(1); ack = 1; tick(); eoi_wr = 1; tick(); idle(1);

    cur_req = "R11";
    for (int k = 2; k < 8; k++) begin dlv('h30 + k, k, 0, 0); tick(); idle(1); end

    cur_req = "R12"; dlv('h61, 0, 0, 0); tick(); ack = 1; tick();
    dlv('h71, 0, 1, 0); tick(); idle(1);
    ack = 1; eoi_wr = 1; tick(); idle(1); eoi_wr = 1; tick(); idle(1);
    dlv('hA1, 0, 0, 0); tick(); dlv('hA1, 0, 1, 0); ack = 1; tick(); idle(1);
    ack = 1; tick(); eoi_wr = 1; tick(); eoi_wr = 1; tick(); idle(2);

    cur_req = "R7"; reg_addr = 1; wr(1, 'h0F0); tick(); dlv('h99, 1, 1, 0); tick(); idle(2);
    ack = 1; tick(); idle(2);

    finish_run();
  end

  initial begin
    wait (cycles > 20000);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=<20000", cycles);
    finish_run();
  end
endmodule